// File: doc/BRIEF.md
# Phase Frequency Detector with Antibacklash Delay

This block compares the output of a reference divider with the output of a feedback divider and turns the time between their edges into two charge-pump requests, `up` and `down`. Each divider edge sets its own request flop. Once both requests are high, a common clear is issued after a programmable hold-off. This hold-off guarantees that both outputs pulse together for a minimum time, so a zero phase error still drives a short, balanced pulse pair. As a result, the transfer function has no dead zone.

Everything runs on one fast clock. The divider pulses are synchronized and edge-detected on that clock. The hold-off length is a count of fast-clock cycles, selected by a 2-bit code. For every comparison, the block also reports how many fast-clock cycles exactly one request was high, and which request came first. A lock detector downstream can use this measurement.

Top module: `pfd_antibacklash`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `up`, `down`, `errValid`, `errWidth` and `errUpLead` are all 0.
- R2: A reference pulse first sampled high at rising edge k makes `up` high after rising edge k+2. This is a two-stage synchronizer followed by one edge-detect register.
- R3: A feedback pulse first sampled high at rising edge k makes `down` high after rising edge k+2, with the same latency as R2.
- R4: A request stays high until both requests have been high together for D cycles, and then both fall on the same edge. `abpCode` selects D: 2'b00 gives 2 (the default, nominal width), 2'b01 gives 1, 2'b10 gives 3 and 2'b11 gives 4.
- R5: When the two edges arrive in the same cycle, `up` and `down` are each high for exactly D cycles.
- R6: `errValid` is high for exactly one cycle, which is the cycle right after the common clear. In that cycle, `errWidth` is the number of cycles in which exactly one request was high, and `errUpLead` is 1 only if `up` was the request that was high alone.
- R7: `errWidth` saturates at 2^MEAS_W-1 (255 by default) when the non-overlap time is longer than that.
- R8: An input edge whose detect pulse falls in the cycle of the clear does not prevent the clear. The edge is held, and it sets its request one cycle after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| refPulse | input | 1 | Reference divider output |
| fbPulse | input | 1 | Feedback divider output |
| abpCode | input | 2 | Antibacklash width code |
| up | output | 1 | Charge-pump up request |
| down | output | 1 | Charge-pump down request |
| errValid | output | 1 | One-cycle strobe marking a finished comparison |
| errWidth | output | MEAS_W | Non-overlap width in fast-clock cycles |
| errUpLead | output | 1 | 1 when the reference edge led |

## Verification
Counting from the rising edge that first samples a divider pulse, a request is due after edge k+2. The common clear lands D edges after the later request rose. The measurement strobe appears on the same edge as the clear, so for a lead of L cycles it is due after edge 2+L+D. The bench drives inputs on the falling edge and records every output on the falling edge after each rising edge. This gives a per-cycle trace indexed by rising-edge number. The first-high index, the high-cycle counts and the strobe index are then compared with those arithmetic expectations.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Strobes sent from the control part to the datapath
  typedef struct packed {
    logic clr;      // clear both request flops on this edge
    logic capture;  // latch the non-overlap measurement on this edge
  } pfdStrobe_t;

  localparam int HOLD_W = 3;

  // Antibacklash hold-off in fast-clock cycles for each code
  function automatic logic [HOLD_W-1:0] holdCycles(input logic [1:0] code);
    logic [HOLD_W-1:0] cyc;
    case (code)
      2'b00:   cyc = 3'd2;
      2'b01:   cyc = 3'd1;
      2'b10:   cyc = 3'd3;
      default: cyc = 3'd4;
    endcase
    return cyc;
  endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], din};
      prevQ <= syncQ[STAGES-1];
    end
  end

  assign rise = syncQ[STAGES-1] & ~prevQ;

endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MEAS_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refIn,
  input  logic              fbIn,
  input  pfdStrobe_t        strobe,
  output logic              upReq,
  output logic              dnReq,
  output logic              errValid,
  output logic [MEAS_W-1:0] errWidth,
  output logic              errUpLead
);
  localparam int CH = 2;  // channel 0 = reference/up, channel 1 = feedback/down
  localparam logic [MEAS_W-1:0] MEAS_MAX = {MEAS_W{1'b1}};

  logic [CH-1:0] chIn;
  logic [CH-1:0] chRise;
  logic [CH-1:0] req;
  logic [CH-1:0] pend;

  assign chIn = {fbIn, refIn};

  for (genvar ch = 0; ch < CH; ch++) begin : g_chan
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (chIn[ch]),
      .rise (chRise[ch])
    );

    // Request flop with data tied high; the clear wins over a same-cycle edge
    always_ff @(posedge clk) begin
      if (rst) begin
        req[ch]  <= 1'b0;
        pend[ch] <= 1'b0;
      end else if (strobe.clr) begin
        req[ch]  <= 1'b0;
        pend[ch] <= chRise[ch];
      end else begin
        req[ch]  <= req[ch] | chRise[ch] | pend[ch];
        pend[ch] <= 1'b0;
      end
    end

    // R2 R3: a request rises only from a detected edge or a held edge
    req_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(req[ch]) |-> $past(chRise[ch] || pend[ch]));

    // R4: a request falls only while the other request is also high
    req_fall_pair_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(req[ch]) |-> $past(req[CH-1-ch]));
  end

  assign upReq = req[0];
  assign dnReq = req[1];

  // Non-overlap measurement
  logic [MEAS_W-1:0] meas;
  logic              leadUp;
  logic              alone;

  assign alone = req[0] ^ req[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      meas   <= '0;
      leadUp <= 1'b0;
    end else if (strobe.clr) begin
      meas   <= '0;
      leadUp <= 1'b0;
    end else begin
      if (alone && meas != MEAS_MAX) meas <= meas + 1'b1;
      if (req[0] && !req[1])         leadUp <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errValid  <= 1'b0;
      errWidth  <= '0;
      errUpLead <= 1'b0;
    end else begin
      errValid <= strobe.capture;
      if (strobe.capture) begin
        errWidth  <= meas;
        errUpLead <= leadUp;
      end
    end
  end

  // R6: the measurement strobe lasts a single cycle
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    errValid |=> !errValid);

  // R6: the strobe follows a cycle in which both requests were high
  valid_after_pair_chk: assert property (@(posedge clk) disable iff (rst)
    errValid |-> $past(req[0] && req[1]));

endmodule

// File: rtl/pfd_control.sv
module pfd_control
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] code,
  input  logic       upReq,
  input  logic       dnReq,
  output pfdStrobe_t strobe
);
  logic [HOLD_W-1:0] overlapCnt;
  logic [HOLD_W-1:0] holdLen;
  logic              both;
  logic              fire;

  assign holdLen = holdCycles(code);
  assign both    = upReq & dnReq;
  assign fire    = both && (overlapCnt >= holdLen - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)              overlapCnt <= '0;
    else if (fire)        overlapCnt <= '0;
    else if (both)        overlapCnt <= overlapCnt + 1'b1;
    else                  overlapCnt <= '0;
  end

  always_comb begin
    strobe.clr     = fire;
    strobe.capture = fire;
  end

  // R4: after the clear both requests are low
  clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.clr |=> (!upReq && !dnReq));

  // R4: a clear is never issued unless the pair has overlapped
  clear_needs_pair_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.clr |-> (upReq && dnReq));

endmodule

// File: rtl/pfd_antibacklash.sv
module pfd_antibacklash
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MEAS_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refPulse,
  input  logic              fbPulse,
  input  logic [1:0]        abpCode,
  output logic              up,
  output logic              down,
  output logic              errValid,
  output logic [MEAS_W-1:0] errWidth,
  output logic              errUpLead
);
  pfdStrobe_t strobe;
  logic       upReq;
  logic       dnReq;

  pfd_control u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .code   (abpCode),
    .upReq  (upReq),
    .dnReq  (dnReq),
    .strobe (strobe)
  );

  pfd_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .MEAS_W      (MEAS_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .refIn     (refPulse),
    .fbIn      (fbPulse),
    .strobe    (strobe),
    .upReq     (upReq),
    .dnReq     (dnReq),
    .errValid  (errValid),
    .errWidth  (errWidth),
    .errUpLead (errUpLead)
  );

  assign up   = upReq;
  assign down = dnReq;

endmodule

// File: tb/tb_pfd_antibacklash.sv
module tb_pfd_antibacklash;
  localparam int CLK_PERIOD = 10;
  localparam int MEAS_W     = 8;
  localparam int TRACE      = 512;
  localparam int MEAS_MAX   = (1 << MEAS_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              refPulse = 1'b0;
  logic              fbPulse = 1'b0;
  logic [1:0]        abpCode = 2'b00;
  logic              up, down, errValid, errUpLead;
  logic [MEAS_W-1:0] errWidth;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  logic upT [TRACE];
  logic dnT [TRACE];
  logic vT  [TRACE];
  int   wT  [TRACE];
  logic lT  [TRACE];

  pfd_antibacklash #(.MEAS_W(MEAS_W)) dut (
    .clk(clk), .rst(rst), .refPulse(refPulse), .fbPulse(fbPulse),
    .abpCode(abpCode), .up(up), .down(down), .errValid(errValid),
    .errWidth(errWidth), .errUpLead(errUpLead)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nChecks = nChecks + 1;
      nFails  = nFails + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks = nChecks + 1;
    if (!ok) begin
      nFails = nFails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int hold(input logic [1:0] c);
    case (c)
      2'b00: return 2;
      2'b01: return 1;
      2'b10: return 3;
      default: return 4;
    endcase
  endfunction

  // Drive one-cycle pulses sampled at the given rising edges (-1 = none),
  // and record the outputs after each rising edge k into the traces.
  task automatic runPattern(input int r0, input int r1, input int f0, input int f1,
                            input int len);
    for (int n = 0; n <= len; n++) begin
      @(negedge clk);
      if (n > 0) begin
        upT[n-1] = up; dnT[n-1] = down; vT[n-1] = errValid;
        wT[n-1] = int'(errWidth); lT[n-1] = errUpLead;
      end
      refPulse = (n == r0) || (n == r1);
      fbPulse  = (n == f0) || (n == f1);
    end
    refPulse = 1'b0;
    fbPulse  = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic int firstHigh(input bit which, input int len);
    for (int k = 0; k < len; k++)
      if ((which ? dnT[k] : upT[k]) === 1'b1) return k;
    return -1;
  endfunction

  task automatic trial(input logic [1:0] c, input int lead);
    int d, mag, refAt, fbAt, len, upCnt, dnCnt, vCnt, vAt;
    d     = hold(c);
    mag   = (lead < 0) ? -lead : lead;
    refAt = (lead < 0) ? mag : 0;
    fbAt  = (lead < 0) ? 0 : mag;
    len   = mag + d + 6;
    abpCode = c;
    runPattern(refAt, -1, fbAt, -1, len);
    upCnt = 0; dnCnt = 0; vCnt = 0; vAt = -1;
    for (int k = 0; k < len; k++) begin
      if (upT[k] === 1'b1) upCnt++;
      if (dnT[k] === 1'b1) dnCnt++;
      if (vT[k] === 1'b1) begin vCnt++; vAt = k; end
    end
    check(firstHigh(1'b0, len) == refAt + 2, "R2 up latency", firstHigh(1'b0, len), refAt + 2);
    check(firstHigh(1'b1, len) == fbAt + 2, "R3 down latency", firstHigh(1'b1, len), fbAt + 2);
    if (lead == 0) begin
      check(upCnt == d && dnCnt == d, "R5 coincident pulse width", upCnt * 100 + dnCnt, d * 101);
    end else begin
      check(upCnt == ((lead > 0) ? mag : 0) + d, "R4 up high cycles", upCnt, ((lead > 0) ? mag : 0) + d);
      check(dnCnt == ((lead < 0) ? mag : 0) + d, "R4 down high cycles", dnCnt, ((lead < 0) ? mag : 0) + d);
    end
    check(vCnt == 1 && vAt == 2 + mag + d, "R6 strobe cycle", vAt, 2 + mag + d);
    if (vAt >= 0) begin
      check(wT[vAt] == ((mag > MEAS_MAX) ? MEAS_MAX : mag), "R6 R7 width", wT[vAt],
            (mag > MEAS_MAX) ? MEAS_MAX : mag);
      check(lT[vAt] == (lead > 0), "R6 lead flag", int'(lT[vAt]), int'(lead > 0));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(up == 0 && down == 0 && errValid == 0 && errWidth == 0 && errUpLead == 0,
          "R1 reset outputs in reset", int'({up, down, errValid, errUpLead}) + int'(errWidth), 0);
    rst = 1'b0;
    @(negedge clk);
    check(up == 0 && down == 0 && errValid == 0 && errWidth == 0 && errUpLead == 0,
          "R1 reset outputs after release", int'({up, down, errValid, errUpLead}) + int'(errWidth), 0);

    for (int c = 0; c < 4; c++)
      for (int l = -6; l <= 6; l++)
        trial(2'(c), l);

    // R7: long lead saturates the width
    trial(2'b11, 300);

    // R8: second reference edge lands in the clear cycle (code 01, D = 1)
    abpCode = 2'b01;
    runPattern(0, 4, 3, 10, 18);
    check(vT[6] === 1'b1 && wT[6] == 3, "R8 first comparison width", wT[6], 3);
    check(upT[6] === 1'b0 && dnT[6] === 1'b0, "R8 both low after clear", int'(upT[6]) + int'(dnT[6]), 0);
    check(upT[7] === 1'b1 && dnT[7] === 1'b0, "R8 held edge sets up", int'(upT[7]), 1);
    check(vT[13] === 1'b1 && wT[13] == 5 && lT[13] === 1'b1, "R8 second comparison width", wT[13], 5);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule